// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a synchronous requester and an asynchronous 256K x 16 DRAM with extended-data-out page mode. It takes one read or write request at a time on an 18-bit word address, with 16-bit data and a byte-enable per lane. It turns each request into a row strobe, column strobe, write enable and output enable sequence. Every strobe width is a whole number of clock cycles.

The row that was last used stays open after each access. When the next request targets the same row, only a new column cycle is issued and the row strobe stays low. A request to a different row first precharges for a programmable number of cycles. Refresh is generated elsewhere. When the refresh sequencer asks, this block closes the open row and grants the bus back. No request is taken until the sequencer reports that DRAM initialisation has finished.

The data bus is presented as separate in, out and per-lane output-enable signals, so that the pad ring can build the bidirectional pins.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row is `req_addr_i[17:9]` and is on `dram_addr_o` when `dram_ras_no` falls. The column is `req_addr_i[8:0]` and is on `dram_addr_o` when a column strobe falls.
- R2: `req_be_i[0]` selects the lower lane (bits 7:0, strobe `dram_lcas_no`) and `req_be_i[1]` selects the upper lane (bits 15:8, strobe `dram_ucas_no`). Only the selected strobes fall. A write leaves the unselected lane of memory unchanged. A read returns zero on an unselected lane.
- R3: For a read, `dram_we_no` is 1 and `dram_oe_no` is 0 while a column strobe is low. For a write, `dram_we_no` is 0 and the selected lanes of `dram_dq_oe_o` are 1 from the cycle before the column strobe falls until it rises, and `dram_oe_no` stays 1.
- R4: Read data is returned on `rdata_o` with a one-cycle pulse of `rdata_valid_o`. Counting from the accepting edge, it arrives T_RCD+1+T_CAS cycles later when no row is open, 1+T_CAS cycles later on a same-row hit, and T_RP+T_RCD+1+T_CAS cycles later on a row miss.
- R5: A request to the open row does not raise `dram_ras_no` and issues only a column cycle.
- R6: `dram_ras_no` stays high for at least T_RP cycles before each fall.
- R7: Only one request is in flight. `req_ready_o` is 0 in the cycle after an accept, and it stays 0 until the access has finished.
- R8: `req_ready_o` is 0 while `init_done_i` is 0, and no row is opened.
- R9: While `ref_req_i` is 1, no request is accepted. An open row is precharged for T_RP cycles, and then `ref_gnt_o` is 1 with the row strobe and both column strobes high.
- R10: During reset, the row strobe, both column strobes, the write enable and the output enable are high, `dram_dq_oe_o` is 0 and `rdata_valid_o` is 0.
- R11: Each column strobe stays low for exactly T_CAS cycles. Between column cycles it stays high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | DRAM initialisation finished |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address: row in 17:9, column in 8:0 |
| req_be_i | input | 2 | Byte-lane enables |
| req_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data; unselected lanes are zero |
| rdata_valid_o | output | 1 | One-cycle read data strobe |
| ref_req_i | input | 1 | Refresh sequencer asks for the bus |
| ref_gnt_o | output | 1 | Row closed and bus idle for refresh |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_lcas_no | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_no | output | 1 | Upper-lane column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data to the pins |
| dram_dq_oe_o | output | 2 | Per-lane pin drive enable |
| dram_dq_i | input | 16 | Data from the pins |

## Verification
Each result has a fixed cycle at which it is due. Counting from the accepting edge, `req_ready_o` drops one cycle later. Read data appears after T_RCD+1+T_CAS, 1+T_CAS or T_RP+T_RCD+1+T_CAS cycles, depending on whether no row is open, the row is hit or the row is missed. The grant follows T_RP+1 cycles after a refresh request that finds a row open. The bench drives inputs and samples outputs on falling edges. It counts those samples from the accepting edge and compares the count with the value its own open-row tracking predicts. A DRAM model in the bench latches the row and column at the falling strobes and times the strobe runs in whole cycles.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_CLOSED,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_CP,
    ST_OPEN,
    ST_PRE
  } edo_state_e;
endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R11: strobe widths come from a steady one-per-cycle countdown
  p_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (set_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (clr_i) begin
      open_q <= 1'b0;
    end
  end

  assign hit_o = open_q && (row_q == cmp_row_i);

  // R5: a row is never opened and closed in one cycle
  p_one_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int DQ_W  = 16,
  parameter int T_RCD = 4,
  parameter int T_CAS = 4,
  parameter int T_CP  = 2,
  parameter int T_RP  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_done_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_we_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DQ_W/8-1:0]      req_be_i,
  input  logic [DQ_W-1:0]        req_wdata_i,
  output logic [DQ_W-1:0]        rdata_o,
  output logic                   rdata_valid_o,
  input  logic                   ref_req_i,
  output logic                   ref_gnt_o,
  output logic [ROW_W-1:0]       dram_addr_o,
  output logic                   dram_ras_no,
  output logic                   dram_lcas_no,
  output logic                   dram_ucas_no,
  output logic                   dram_we_no,
  output logic                   dram_oe_no,
  output logic [DQ_W-1:0]        dram_dq_o,
  output logic [DQ_W/8-1:0]      dram_dq_oe_o,
  input  logic [DQ_W-1:0]        dram_dq_i
);
  localparam int AW   = ROW_W + COL_W;
  localparam int NB   = DQ_W / 8;
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int HW   = $clog2(T_RP + 1);

  edo_state_e state_q, state_d;

  logic             r_we;
  logic [ROW_W-1:0] r_row;
  logic [COL_W-1:0] r_col;
  logic [NB-1:0]    r_be;
  logic [DQ_W-1:0]  r_wdata;
  logic             pend_q, pend_d;

  logic          accept, latch, hit, cap;
  logic          tload, tdone;
  logic [CW-1:0] tval;
  logic          trk_set, trk_clr;
  logic [ROW_W-1:0] trk_row;
  logic [DQ_W-1:0]  rdata_q;
  logic             rvalid_q;
  logic [NB-1:0]    lane_cas_n;
  logic             col_phase;

  assign req_ready_o = init_done_i && !ref_req_i &&
                       (state_q == ST_CLOSED || state_q == ST_OPEN);
  assign accept      = req_valid_i && req_ready_o;
  assign ref_gnt_o   = ref_req_i && (state_q == ST_CLOSED);
  assign trk_row     = latch ? req_addr_i[AW-1:COL_W] : r_row;

  edo_timer #(.W(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tload),
    .val_i  (tval),
    .done_o (tdone)
  );

  edo_row_track #(.ROW_W(ROW_W)) i_row_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (trk_set),
    .clr_i     (trk_clr),
    .row_i     (trk_row),
    .cmp_row_i (req_addr_i[AW-1:COL_W]),
    .hit_o     (hit)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    tload   = 1'b0;
    tval    = '0;
    latch   = 1'b0;
    trk_set = 1'b0;
    trk_clr = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      ST_CLOSED: if (accept) begin
        latch   = 1'b1;
        trk_set = 1'b1;
        tload   = 1'b1;
        tval    = CW'(T_RCD - 1);
        state_d = ST_RAS;
      end
      ST_RAS: if (tdone) state_d = ST_COL;
      ST_COL: begin
        tload   = 1'b1;
        tval    = CW'(T_CAS - 1);
        state_d = ST_CAS;
      end
      ST_CAS: if (tdone) begin
        cap     = !r_we;
        tload   = 1'b1;
        tval    = CW'(T_CP - 1);
        state_d = ST_CP;
      end
      ST_CP: if (tdone) state_d = ST_OPEN;
      ST_OPEN: begin
        if (ref_req_i) begin
          trk_clr = 1'b1;
          pend_d  = 1'b0;
          tload   = 1'b1;
          tval    = CW'(T_RP - 1);
          state_d = ST_PRE;
        end else if (accept) begin
          latch = 1'b1;
          if (hit) begin
            state_d = ST_COL;
          end else begin
            trk_clr = 1'b1;
            pend_d  = 1'b1;
            tload   = 1'b1;
            tval    = CW'(T_RP - 1);
            state_d = ST_PRE;
          end
        end
      end
      ST_PRE: if (tdone) begin
        if (pend_q) begin
          trk_set = 1'b1;
          pend_d  = 1'b0;
          tload   = 1'b1;
          tval    = CW'(T_RCD - 1);
          state_d = ST_RAS;
        end else begin
          state_d = ST_CLOSED;
        end
      end
      default: state_d = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CLOSED;
      pend_q   <= 1'b0;
      r_we     <= 1'b0;
      r_row    <= '0;
      r_col    <= '0;
      r_be     <= '0;
      r_wdata  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      rvalid_q <= cap;
      if (latch) begin
        r_we    <= req_we_i;
        r_row   <= req_addr_i[AW-1:COL_W];
        r_col   <= req_addr_i[COL_W-1:0];
        r_be    <= req_be_i;
        r_wdata <= req_wdata_i;
      end
    end
  end

  assign col_phase = (state_q == ST_COL) || (state_q == ST_CAS);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_cas_n[b]   = !((state_q == ST_CAS) && r_be[b]);
    assign dram_dq_oe_o[b] = col_phase && r_we && r_be[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  rdata_q[b*8 +: 8] <= '0;
      else if (cap) rdata_q[b*8 +: 8] <= r_be[b] ? dram_dq_i[b*8 +: 8] : 8'h00;
    end
  end

  assign dram_ras_no   = (state_q == ST_CLOSED) || (state_q == ST_PRE);
  assign dram_lcas_no  = lane_cas_n[0];
  assign dram_ucas_no  = lane_cas_n[NB-1];
  assign dram_we_no    = !(col_phase && r_we);
  assign dram_oe_no    = !(col_phase && !r_we);
  assign dram_addr_o   = (state_q == ST_RAS || state_q == ST_CLOSED || state_q == ST_PRE)
                         ? r_row : ROW_W'(r_col);
  assign dram_dq_o     = r_wdata;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;

  // precharge run length watched beside the row strobe
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_cnt_q <= HW'(T_RP);
    else if (!dram_ras_no)     hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(T_RP)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_ras_precharge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (hi_cnt_q >= HW'(T_RP)));
  p_cas_in_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_lcas_no || !dram_ucas_no) |-> !dram_ras_no);
  p_early_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(dram_lcas_no) || $fell(dram_ucas_no)) && !dram_we_no) |-> $past(!dram_we_no));
  p_oe_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> dram_we_no);
  p_drive_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dram_dq_oe_o) |-> !dram_we_no);
  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
  p_page_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && accept && hit) |=> !dram_ras_no);
  p_one_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  p_ready_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> init_done_i);
  p_gnt_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (dram_ras_no && dram_lcas_no && dram_ucas_no));
endmodule

// File: tb/test_edo_dram_ctrl.sv
`timescale 1ns/1ps
module test_edo_dram_ctrl;
  localparam int T_RCD = 4;
  localparam int T_CAS = 4;
  localparam int T_CP  = 2;
  localparam int T_RP  = 6;
  localparam int LAT_CLOSED = T_RCD + 1 + T_CAS;
  localparam int LAT_HIT    = 1 + T_CAS;
  localparam int LAT_MISS   = T_RP + T_RCD + 1 + T_CAS;

  typedef struct packed {
    logic        we;
    logic [17:0] addr;
    logic [1:0]  be;
    logic [15:0] wdata;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 18'h00405, 2'b11, 16'h1234},
    '{1'b0, 18'h00405, 2'b11, 16'h0000},
    '{1'b1, 18'h00406, 2'b01, 16'hAB77},
    '{1'b0, 18'h00406, 2'b11, 16'h0000},
    '{1'b0, 18'h00406, 2'b10, 16'h0000},
    '{1'b0, 18'h00601, 2'b11, 16'h0000},
    '{1'b1, 18'h00601, 2'b10, 16'h55C3},
    '{1'b0, 18'h00601, 2'b01, 16'h0000},
    '{1'b0, 18'h00601, 2'b11, 16'h0000},
    '{1'b0, 18'h00405, 2'b11, 16'h0000},
    '{1'b1, 18'h3FFFF, 2'b11, 16'hBEEF},
    '{1'b0, 18'h3FFFF, 2'b11, 16'h0000},
    '{1'b0, 18'h00000, 2'b11, 16'h0000},
    '{1'b0, 18'h3FFFF, 2'b10, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0, req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rdata_valid, ref_gnt;
  logic [15:0] rdata, dq_o, dq_i;
  logic [8:0]  dram_addr;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [1:0]  dq_oe;

  always #2 clk = ~clk;

  edo_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)) i_edo_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid),
    .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_addr_o(dram_addr), .dram_ras_no(ras_n), .dram_lcas_no(lcas_n),
    .dram_ucas_no(ucas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic int idx_of(input logic [8:0] row, input logic [8:0] col);
    return int'({row[4:0], col[4:0]});
  endfunction

  // DRAM model, sampled on falling clock edges
  logic [15:0] mem    [1024];
  logic [15:0] shadow [1024];
  logic [8:0]  m_row = '0, m_col = '0;
  int ras_falls = 0;
  int ras_hi_run = T_RP;
  int cas_lo_run = 0;
  int cas_hi_run = 100;
  logic p_ras = 1'b1, p_cas = 1'b0, p_we = 1'b1;

  assign dq_i = {(!ucas_n && !oe_n) ? mem[idx_of(m_row, m_col)][15:8] : 8'hEE,
                 (!lcas_n && !oe_n) ? mem[idx_of(m_row, m_col)][7:0]  : 8'hEE};

  always @(negedge clk) begin
    if (rst_n) begin
      logic cas_any;
      cas_any = !lcas_n || !ucas_n;
      if (!ras_n && p_ras) begin
        m_row = dram_addr;
        ras_falls++;
        check(ras_hi_run >= T_RP, "R6 precharge", ras_hi_run, T_RP);
      end
      if (cas_any && !p_cas) begin
        m_col = dram_addr;
        check(cas_hi_run >= T_CP, "R11 cas high gap", cas_hi_run, T_CP);
        if (!we_n) begin
          check(!p_we && oe_n, "R3 early write", {p_we, oe_n}, 2'b01);
          check(dq_oe == {!ucas_n, !lcas_n}, "R3 lane drive", dq_oe, {!ucas_n, !lcas_n});
          if (!lcas_n) mem[idx_of(m_row, dram_addr)][7:0]  = dq_o[7:0];
          if (!ucas_n) mem[idx_of(m_row, dram_addr)][15:8] = dq_o[15:8];
        end else begin
          check(!oe_n, "R3 read oe", oe_n, 0);
        end
      end
      if (!cas_any && p_cas)
        check(cas_lo_run == T_CAS, "R11 cas width", cas_lo_run, T_CAS);
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = cas_any ? cas_lo_run + 1 : 0;
      cas_hi_run = cas_any ? 0 : cas_hi_run + 1;
      p_ras = ras_n;
      p_cas = cas_any;
      p_we  = we_n;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  int bench_open = -1;

  task automatic do_access(input vec_t v);
    int k;
    int lat;
    int falls0;
    int row;
    int id;
    logic [15:0] exp;
    row = int'(v.addr[17:9]);
    id  = idx_of(v.addr[17:9], v.addr[8:0]);
    lat = (bench_open < 0) ? LAT_CLOSED : (row == bench_open ? LAT_HIT : LAT_MISS);
    while (!req_ready) @(negedge clk);
    falls0    = ras_falls;
    req_valid = 1'b1;
    req_we    = v.we;
    req_addr  = v.addr;
    req_be    = v.be;
    req_wdata = v.wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    check(!req_ready, "R7 busy after accept", req_ready, 0);
    if (!v.we) begin
      while (!rdata_valid && k < 200) begin
        @(negedge clk);
        k++;
      end
      check(k == lat, "R4 read latency", k, lat);
      exp = {v.be[1] ? shadow[id][15:8] : 8'h00, v.be[0] ? shadow[id][7:0] : 8'h00};
      check(rdata == exp, (v.be == 2'b11) ? "R1 word read data" : "R2 byte read data", rdata, exp);
      @(negedge clk);
      check(!rdata_valid, "R4 single pulse", rdata_valid, 0);
    end
    k = 0;
    while (!req_ready && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(m_row == v.addr[17:9], "R1 row latched", m_row, v.addr[17:9]);
    check(m_col == v.addr[8:0], "R1 col latched", m_col, v.addr[8:0]);
    check(ras_falls - falls0 == ((row == bench_open) ? 0 : 1), "R5 row opens",
          ras_falls - falls0, (row == bench_open) ? 0 : 1);
    if (v.we) begin
      if (v.be[0]) shadow[id][7:0]  = v.wdata[7:0];
      if (v.be[1]) shadow[id][15:8] = v.wdata[15:8];
    end
    bench_open = row;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = pat(i);
      shadow[i] = pat(i);
    end
    repeat (3) @(negedge clk);
    // R10: standby during reset
    check(ras_n && lcas_n && ucas_n && we_n && oe_n, "R10 strobes idle",
          {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1F);
    check(dq_oe == 2'b00 && !rdata_valid, "R10 bus released", {dq_oe, rdata_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: no acceptance before init completes
    req_valid = 1'b1;
    req_addr  = 18'h00405;
    req_be    = 2'b11;
    for (int i = 0; i < 5; i++) begin
      check(!req_ready, "R8 ready held low", req_ready, 0);
      @(negedge clk);
    end
    check(ras_falls == 0 && ras_n, "R8 no row opened", ras_falls, 0);
    req_valid = 1'b0;
    init_done = 1'b1;
    @(negedge clk);
    check(req_ready, "R8 ready after init", req_ready, 1);

    for (int n = 0; n < NV; n++) do_access(VEC[n]);

    // R9: refresh closes the open row and grants
    begin
      int k;
      int falls0;
      ref_req   = 1'b1;
      req_valid = 1'b1;
      req_addr  = VEC[NV-1].addr;
      req_we    = 1'b0;
      falls0    = ras_falls;
      k = 0;
      @(negedge clk);
      k++;
      check(!req_ready, "R9 no accept during refresh", req_ready, 0);
      while (!ref_gnt && k < 200) begin
        @(negedge clk);
        k++;
      end
      check(k == T_RP + 1, "R9 grant delay", k, T_RP + 1);
      check(ras_n && lcas_n && ucas_n, "R9 bus idle at grant", {ras_n, lcas_n, ucas_n}, 3'b111);
      repeat (4) @(negedge clk);
      check(ras_falls == falls0 && ref_gnt, "R9 row stays closed", ras_falls - falls0, 0);
      req_valid = 1'b0;
      ref_req   = 1'b0;
      bench_open = -1;
      @(negedge clk);
    end
    do_access('{1'b0, 18'h00405, 2'b11, 16'h0000});
    do_access('{1'b0, 18'h00406, 2'b01, 16'h0000});

    finish_run();
  end
endmodule